// File: doc/BRIEF.md
# Single-Byte I2C Master

This block is a bus master that moves one byte per transaction to or from a memory-style slave over the two-wire I2C bus. It runs from a fast system clock and divides it internally into a bit-rate reference. All bus activity is paced by that reference: one bit slot per reference period.

The user raises `newdata` with the transfer direction (`wr`), a 7-bit slave address and, for writes, a data byte. The block latches these values and performs the transfer. A write sends a start, the address byte, waits for an acknowledge, sends the data byte, waits for an acknowledge and sends a stop. A read sends a start and the address byte, waits for an acknowledge, clocks in eight bits and sends a stop. A one-period `done` pulse marks the end of the transfer, and a read result appears on `rdata`.

If the slave withholds an acknowledge, the master keeps clocking acknowledge slots until the slave pulls SDA low. It never gives up and returns to idle.

Top module: `i2c_byte_master`

## Requirements
- R1: With N = SYS_HZ / BIT_HZ, SCL pulses during bit slots are high for exactly N/2 system cycles and repeat every N cycles.
- R2: In idle, SCL, `sda_out` and `sda_oe` are all 1. A start is SDA falling while SCL is high, after SCL has already been high for at least one full reference period.
- R3: The first byte sent after a start is {addr[6:0], ~wr}, MSB first, so bit 0 is 0 for a write and 1 for a read.
- R4: In every acknowledge slot `sda_oe` is 0. While the slave leaves SDA high, the master keeps clocking further acknowledge slots, with no stop and no `done`. The first slot with SDA low lets the transfer proceed.
- R5: In a write, the latched data byte is sent MSB first after the address acknowledge, followed by its own acknowledge slot.
- R6: In a read, `sda_oe` is 0 during the eight data slots. The bits sampled on SCL rising edges, first bit as MSB, appear on `rdata` by the time `done` rises, and `rdata` holds that value afterwards.
- R7: A transfer ends with exactly one stop, SDA rising while SCL is high, and `done` is then high for exactly N system cycles with SCL, `sda_out` and `sda_oe` all at 1.
- R8: Address, direction and write data are captured when the transfer begins. Changing them during the transfer does not alter the bytes on the bus.
- R9: While reset is asserted, and until the first reference period after it, SCL, `sda_out`, `done` and `rdata` are 0.
- R10: A new transfer is taken only from idle with `newdata` high. With `newdata` low no start occurs, and each accepted request makes exactly one start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| newdata | input | 1 | Transfer request, sampled in idle at reference boundaries |
| wr | input | 1 | 1 = write, 0 = read |
| addr | input | 7 | Slave address |
| wdata | input | 8 | Byte to write |
| rdata | output | 8 | Byte read by the last read transfer |
| done | output | 1 | High for one reference period at the end of a transfer |
| scl | output | 1 | Bus clock |
| sda_out | output | 1 | SDA value driven when enabled |
| sda_oe | output | 1 | SDA output enable; 0 releases the line |
| sda_in | input | 1 | Sampled SDA level |

## Verification
A sequencer that has slipped into the wrong state shows up on SDA within one reference period. Typical symptoms are a wrong address or data bit at the next SCL rising edge, the enable staying on in an acknowledge slot, or a stop appearing too early. A wrong count in the acknowledge wait shows as a wrong number of acknowledge slots before the stop. A corrupted latch shows as a wrong captured byte once the transfer completes. A divider fault shows as the first SCL high time differing from N/2.

// File: rtl/i2c_byte_master.sv
module i2c_byte_master #(
  parameter int SYS_HZ = 100_000_000,
  parameter int BIT_HZ = 400_000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       newdata,
  input  logic       wr,
  input  logic [6:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       done,
  output logic       scl,
  output logic       sda_out,
  output logic       sda_oe,
  input  logic       sda_in
);
  localparam int N    = SYS_HZ / BIT_HZ;
  localparam int HALF = N / 2;
  localparam int CW   = (HALF > 1) ? $clog2(HALF) : 1;

  localparam logic [3:0] S_IDLE = 4'd0, S_STA1 = 4'd1, S_STA2 = 4'd2, S_ADDR = 4'd3,
                         S_AACK = 4'd4, S_WDAT = 4'd5, S_DACK = 4'd6, S_RDAT = 4'd7,
                         S_STO1 = 4'd8, S_STO2 = 4'd9;

  logic [CW-1:0] div;
  logic          ref_q;
  logic [3:0]    state;
  logic [2:0]    bitn;
  logic [7:0]    addr_r, data_r, rx, rdata_q;
  logic          ack_s, drv_hi, clk_en, sda_q, oe_q, done_q;

  wire wrap = (div == CW'(HALF - 1));
  wire step = wrap & ref_q;
  wire rise = wrap & ~ref_q;

  assign scl     = drv_hi | (clk_en & ref_q);
  assign sda_out = sda_q;
  assign sda_oe  = oe_q;
  assign done    = done_q;
  assign rdata   = rdata_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      div     <= '0;
      ref_q   <= 1'b0;
      state   <= S_IDLE;
      bitn    <= '0;
      addr_r  <= '0;
      data_r  <= '0;
      rx      <= '0;
      rdata_q <= '0;
      ack_s   <= 1'b1;
      drv_hi  <= 1'b0;
      clk_en  <= 1'b0;
      sda_q   <= 1'b0;
      oe_q    <= 1'b1;
      done_q  <= 1'b0;
    end else begin
      div <= wrap ? '0 : div + 1'b1;
      if (wrap) ref_q <= ~ref_q;

      if (rise) begin
        if (state == S_AACK || state == S_DACK) ack_s <= sda_in;
        if (state == S_RDAT) rx <= {rx[6:0], sda_in};
      end

      if (step) begin
        done_q <= 1'b0;
        case (state)
          S_IDLE: begin
            drv_hi <= 1'b1;
            clk_en <= 1'b0;
            sda_q  <= 1'b1;
            oe_q   <= 1'b1;
            if (newdata) begin
              addr_r <= {addr, ~wr};
              data_r <= wdata;
              state  <= S_STA1;
            end
          end
          S_STA1: begin
            sda_q <= 1'b0;
            state <= S_STA2;
          end
          S_STA2: begin
            drv_hi <= 1'b0;
            clk_en <= 1'b1;
            sda_q  <= addr_r[7];
            bitn   <= 3'd7;
            state  <= S_ADDR;
          end
          S_ADDR: begin
            if (bitn == 3'd0) begin
              oe_q  <= 1'b0;
              state <= S_AACK;
            end else begin
              sda_q <= addr_r[bitn - 3'd1];
              bitn  <= bitn - 3'd1;
            end
          end
          S_AACK: begin
            if (!ack_s) begin
              bitn <= 3'd7;
              if (addr_r[0]) begin
                state <= S_RDAT;
              end else begin
                oe_q  <= 1'b1;
                sda_q <= data_r[7];
                state <= S_WDAT;
              end
            end
          end
          S_WDAT: begin
            if (bitn == 3'd0) begin
              oe_q  <= 1'b0;
              state <= S_DACK;
            end else begin
              sda_q <= data_r[bitn - 3'd1];
              bitn  <= bitn - 3'd1;
            end
          end
          S_DACK: begin
            if (!ack_s) begin
              oe_q  <= 1'b1;
              sda_q <= 1'b0;
              state <= S_STO1;
            end
          end
          S_RDAT: begin
            if (bitn == 3'd0) begin
              rdata_q <= rx;
              oe_q    <= 1'b1;
              sda_q   <= 1'b0;
              state   <= S_STO1;
            end else begin
              bitn <= bitn - 3'd1;
            end
          end
          S_STO1: begin
            drv_hi <= 1'b1;
            clk_en <= 1'b0;
            sda_q  <= 1'b1;
            done_q <= 1'b1;
            state  <= S_STO2;
          end
          default: state <= S_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_byte_master_chk.sv
module i2c_byte_master_chk #(
  parameter int N = 2
) (
  input logic       clk,
  input logic       rst,
  input logic [3:0] state,
  input logic [7:0] addr_r,
  input logic       done,
  input logic       scl,
  input logic       sda_out,
  input logic       sda_oe
);
  int dlen;

  always_ff @(posedge clk) begin
    if (rst) dlen <= 0;
    else     dlen <= done ? dlen + 1 : 0;
  end

  AST_START_SCL_HIGH: assert property (@(posedge clk) disable iff (rst)
    (state == 4'd1 || state == 4'd2) |-> scl); // R2
  AST_ACK_RELEASED: assert property (@(posedge clk) disable iff (rst)
    (state == 4'd4 || state == 4'd6) |-> !sda_oe); // R4
  AST_DONE_LINES_HIGH: assert property (@(posedge clk) disable iff (rst)
    done |-> (scl && sda_out && sda_oe)); // R7
  AST_DONE_BOUNDED: assert property (@(posedge clk) disable iff (rst)
    dlen <= N); // R7
  AST_LATCH_HELD: assert property (@(posedge clk) disable iff (rst)
    (state != 4'd0) |=> $stable(addr_r)); // R8
  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (!done && !scl && !sda_out)); // R9
endmodule

bind i2c_byte_master i2c_byte_master_chk #(.N(N)) chk_i (
  .clk(clk), .rst(rst), .state(state), .addr_r(addr_r), .done(done),
  .scl(scl), .sda_out(sda_out), .sda_oe(sda_oe)
);

// File: tb/i2c_byte_master_tb_top.sv
module i2c_byte_master_tb_top;
  localparam int SYS_HZ = 16;
  localparam int BIT_HZ = 2;
  localparam int N      = SYS_HZ / BIT_HZ;
  localparam int HALF   = N / 2;

  // {wr, addr[6:0], wdata, slave read byte, addr nacks, data nacks}
  localparam logic [27:0] VEC [6] = '{
    {1'b1, 7'h50, 8'hA5, 8'h00, 2'd0, 2'd0},
    {1'b0, 7'h50, 8'h00, 8'h3C, 2'd0, 2'd0},
    {1'b1, 7'h7F, 8'hFF, 8'h00, 2'd3, 2'd2},
    {1'b0, 7'h00, 8'h00, 8'h81, 2'd2, 2'd0},
    {1'b1, 7'h01, 8'h00, 8'h00, 2'd0, 2'd1},
    {1'b0, 7'h2A, 8'h00, 8'hFF, 2'd1, 2'd0}
  };

  logic clk = 1'b0, rst = 1'b1, newdata = 1'b0, wr = 1'b0, sda_in = 1'b1;
  logic [6:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic done, scl, sda_out, sda_oe;

  always #2.5 clk = ~clk;

  i2c_byte_master #(.SYS_HZ(SYS_HZ), .BIT_HZ(BIT_HZ)) dut_i (
    .clk(clk), .rst(rst), .newdata(newdata), .wr(wr), .addr(addr), .wdata(wdata),
    .rdata(rdata), .done(done), .scl(scl), .sda_out(sda_out), .sda_oe(sda_oe),
    .sda_in(sda_in)
  );

  int vecs = 0, bad = 0;
  int slot = 0, starts = 0, stops = 0, aslots = 0, dslots = 0;
  int hi_run = 0, hi_bad = 0, oe_bad = 0, dlen = 0, na_left = 0, nd_left = 0;
  bit xfer = 0;
  bit [7:0] ab = 0, db = 0, rbyte = 0;
  logic pscl = 1'b0, psda = 1'b0;

  task automatic chk(input string req, input int act, input int exp);
    vecs++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  endtask

  // slave model and bus monitor, sampled away from the active edge
  always @(negedge clk) begin
    if (done) dlen++;
    if (scl && !pscl && xfer) begin
      if (slot < 8) begin
        ab = {ab[6:0], sda_out};
        slot++;
      end else if (slot == 8) begin
        aslots++;
        if (sda_oe) oe_bad++;
        if (!sda_in) slot++;
      end else if (slot < 17) begin
        if (!ab[0]) db = {db[6:0], sda_out};
        else if (sda_oe) oe_bad++;
        slot++;
      end else if (slot == 17 && !ab[0]) begin
        dslots++;
        if (sda_oe) oe_bad++;
        if (!sda_in) slot++;
      end
    end
    if (!scl && pscl && xfer) begin
      if (slot >= 1 && slot <= 8 && hi_run != HALF) hi_bad++;
      if (slot == 8) begin
        if (na_left > 0) begin na_left--; sda_in = 1'b1; end
        else sda_in = 1'b0;
      end else if (slot == 17 && !ab[0]) begin
        if (nd_left > 0) begin nd_left--; sda_in = 1'b1; end
        else sda_in = 1'b0;
      end else if (slot >= 9 && slot < 17 && ab[0]) begin
        sda_in = rbyte[16 - slot];
      end else begin
        sda_in = 1'b1;
      end
    end
    if (scl && pscl && psda && !sda_out && sda_oe) begin
      starts++;
      xfer = 1'b1;
      slot = 0;
      if (hi_run < N) hi_bad++;
    end
    if (scl && pscl && !psda && sda_out && sda_oe) begin
      stops++;
      xfer = 1'b0;
      sda_in = 1'b1;
    end
    hi_run = scl ? hi_run + 1 : 0;
    pscl = scl;
    psda = sda_out;
  end

  task automatic run_xfer(input bit w, input bit [6:0] a, input bit [7:0] d,
                          input bit [7:0] rb, input int na, input int nd, input bit mutate);
    @(negedge clk);
    starts = 0; stops = 0; aslots = 0; dslots = 0; hi_bad = 0; oe_bad = 0; dlen = 0;
    ab = 0; db = 0; rbyte = rb; na_left = na; nd_left = nd;
    wr = w; addr = a; wdata = d; newdata = 1'b1;
    if (mutate) begin
      while (starts == 0) @(negedge clk);
      wr = ~w; addr = ~a; wdata = ~d;
    end
    while (!done) @(negedge clk);
    while (done) @(negedge clk);
    newdata = 1'b0;
    chk("R3 address byte", int'(ab), int'({a, ~w}));
    chk("R4 address ack slots", aslots, na + 1);
    chk("R4 enable released in ack and read slots", oe_bad, 0);
    if (w) begin
      chk("R5 data byte", int'(db), int'(d));
      chk("R5 data ack slots", dslots, nd + 1);
    end else begin
      chk("R6 read byte on rdata", int'(rdata), int'(rb));
    end
    chk("R7 single stop", stops, 1);
    chk("R7 done width", dlen, N);
    chk("R10 single start per request", starts, 1);
    chk("R1 R2 SCL high timing", hi_bad, 0);
    if (mutate) begin
      chk("R8 latched address survives input change", int'(ab), int'({a, ~w}));
      chk("R8 latched data survives input change", int'(db), int'(d));
    end
  endtask

  initial begin
    #(5.0 * 150000);
    bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R9 scl in reset", int'(scl), 0);
    chk("R9 done in reset", int'(done), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R9 scl after reset", int'(scl), 0);
    chk("R9 sda after reset", int'(sda_out), 0);
    chk("R9 rdata after reset", int'(rdata), 0);
    repeat (2 * N) @(negedge clk);
    chk("R2 idle scl", int'(scl), 1);
    chk("R2 idle sda", int'(sda_out), 1);
    chk("R2 idle enable", int'(sda_oe), 1);
    repeat (10 * N) @(negedge clk);
    chk("R10 no start without request", starts, 0);

    for (int i = 0; i < 6; i++) begin
      run_xfer(VEC[i][27], VEC[i][26:20], VEC[i][19:12], VEC[i][11:4],
               int'(VEC[i][3:2]), int'(VEC[i][1:0]), 1'b0);
    end

    run_xfer(1'b1, 7'h33, 8'h6D, 8'h00, 1, 0, 1'b1);
    run_xfer(1'b0, 7'h4C, 8'h00, 8'hC3, 0, 0, 1'b0);
    chk("R6 rdata holds after read", int'(rdata), 8'hC3);

    repeat (3 * N) @(negedge clk);
    chk("R2 idle scl after transfers", int'(scl), 1);
    chk("R2 idle sda after transfers", int'(sda_out), 1);
    chk("R10 no extra start after request drops", starts, 1);
    finish_run();
  end
endmodule